// File: doc/BRIEF.md
# Legacy Port 92 Fast Reset and A20 Gate Controller

This block serves the single legacy host I/O register at address 92h. Through it the host can request a fast CPU reset or set an alternate A20 gate level without going through the keyboard controller. Host I/O writes that hit 92h load an 8-bit register. A 0-to-1 change on bit 0 fires a fixed-length CPU reset pulse. Bit 1 is ORed into the A20 gate output together with the host-controlled A20 level. Host reads of 92h return the register and raise a data drive enable.

A port enable input shuts the register off from the host completely. While it is low, writes are dropped and reads leave the data bus undriven. Firmware can take over the A20 gate. When the speed-up enable input is high, the output follows a 1-bit firmware control register instead of the host path.

Top module: `a20rst_port_ctl`

## Requirements
- R1: After reset the register reads 00h, the firmware A20 bit is 0, `cpu_rst` is low, and with speed-up disabled `a20_gate` equals `host_a20`.
- R2: A write (`io_wr`) to address 0092h with the port enabled loads `io_wdata` into the register at that clock edge. A later read (`io_rd`) of 0092h returns all 8 bits as written, bit 0 included, on `io_rdata` with `io_rdata_oe` high in the same cycle.
- R3: Only the full address 0092h is decoded. Writes to any other address leave the register unchanged. Reads of any other address keep `io_rdata_oe` low and `io_rdata` at 00h.
- R4: While `port_en` is 0, writes to 0092h are ignored: the register does not change and no reset pulse starts. Reads of 0092h keep `io_rdata_oe` low and `io_rdata` at 00h.
- R5: An accepted write that sets register bit 0 while it was 0 raises `cpu_rst` from the next cycle on, for exactly PULSE_CYCLES (default 16) cycles.
- R6: A 0-to-1 write on bit 0 while the pulse is active does not lengthen it. Writing 1 to bit 0 when it already holds 1 starts no pulse.
- R7: With `speed_up_en` at 0, `a20_gate` is the OR of `host_a20` and register bit 1.
- R8: With `speed_up_en` at 1, `a20_gate` equals the firmware A20 bit. That bit is loaded from `fw_a20_wdata` at a clock edge where `fw_a20_we` is 1, and neither `host_a20` nor register bit 1 affects the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low I/O reset |
| io_addr | input | 16 | Host I/O address |
| io_wr | input | 1 | Host I/O write strobe, one cycle per access |
| io_rd | input | 1 | Host I/O read strobe |
| io_wdata | input | 8 | Host write data |
| io_rdata | output | 8 | Host read data, 00h when not driven |
| io_rdata_oe | output | 1 | Read data drive enable |
| port_en | input | 1 | Port enable; 0 blocks all host access |
| speed_up_en | input | 1 | Gives the A20 output to the firmware bit |
| fw_a20_we | input | 1 | Firmware A20 bit write strobe |
| fw_a20_wdata | input | 1 | Firmware A20 bit write value |
| host_a20 | input | 1 | Host-path A20 level |
| a20_gate | output | 1 | A20 gate output |
| cpu_rst | output | 1 | Alternate CPU reset pulse, active high |

## Verification
The bench sends writes to 0093h and to 0192h, so a decoder that compares only the low address byte would corrupt the register. It also reads the register back while the port is disabled and checks that no write slipped through. It rewrites bit 0 in the middle of an active pulse and again after the pulse ends: a level-triggered or retriggerable design would stretch the pulse or fire a second one. It drives `host_a20` and register bit 1 against the firmware bit with speed-up on, which catches a mux that ORs all three sources or chooses them in the wrong order.

// File: rtl/a20rst_pkg.sv
package a20rst_pkg;

    // Registered state of the port controller.
    typedef struct packed {
        logic [7:0] reg92;   // bit 1: alternate A20, bit 0: reset request
        logic       fw_a20;  // firmware-owned A20 level
    } ctl_state_t;

    localparam ctl_state_t CTL_RESET = '{reg92: 8'h00, fw_a20: 1'b0};

endpackage

// File: rtl/a20rst_addr_dec.sv
module a20rst_addr_dec #(
    parameter int              ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] PORT_ADDR = 'h92
) (
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              port_en,
    output logic              hit_o
);

    // Full-width compare: aliases at other pages must not hit.
    always_comb begin
        hit_o = port_en && (io_addr == PORT_ADDR);
    end

endmodule

// File: rtl/a20rst_pulse_gen.sv
module a20rst_pulse_gen #(
    parameter int PULSE_CYCLES = 16,
    localparam int CNT_W       = $clog2(PULSE_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic pulse_o
);

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic             busy;

    always_comb begin
        busy  = (cnt_q != '0);
        cnt_d = cnt_q;
        if (busy) begin
            cnt_d = cnt_q - 1'b1;           // no reload while running
        end else if (start_i) begin
            cnt_d = CNT_W'(PULSE_CYCLES);
        end
        pulse_o = busy;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_PULSE_START: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !pulse_o) |=> pulse_o);                                   // R5
    AST_NO_EXTEND: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && pulse_o) |=> (cnt_q == $past(cnt_q) - 1'b1));             // R6

endmodule

// File: rtl/a20rst_a20_mux.sv
module a20rst_a20_mux (
    input  logic speed_up_en,
    input  logic fw_a20,
    input  logic host_a20,
    input  logic alt_a20,
    output logic a20_o
);

    // Firmware path wins outright; otherwise either host source opens A20.
    always_comb begin
        if (speed_up_en) a20_o = fw_a20;
        else             a20_o = host_a20 | alt_a20;
    end

endmodule

// File: rtl/a20rst_port_ctl.sv
module a20rst_port_ctl
    import a20rst_pkg::*;
#(
    parameter int              ADDR_W       = 16,
    parameter logic [ADDR_W-1:0] PORT_ADDR    = 'h92,
    parameter int              PULSE_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata,
    output logic              io_rdata_oe,
    input  logic              port_en,
    input  logic              speed_up_en,
    input  logic              fw_a20_we,
    input  logic              fw_a20_wdata,
    input  logic              host_a20,
    output logic              a20_gate,
    output logic              cpu_rst
);

    ctl_state_t state_d, state_q;
    logic       hit;
    logic       wr_hit;
    logic       rst_start;

    a20rst_addr_dec #(
        .ADDR_W   (ADDR_W),
        .PORT_ADDR(PORT_ADDR)
    ) i_dec (
        .io_addr(io_addr),
        .port_en(port_en),
        .hit_o  (hit)
    );

    always_comb begin
        state_d   = state_q;
        wr_hit    = io_wr && hit;
        rst_start = wr_hit && io_wdata[0] && !state_q.reg92[0];
        if (wr_hit)    state_d.reg92  = io_wdata;
        if (fw_a20_we) state_d.fw_a20 = fw_a20_wdata;
        io_rdata_oe = io_rd && hit;
        io_rdata    = io_rdata_oe ? state_q.reg92 : 8'h00;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CTL_RESET;
        else        state_q <= state_d;
    end

    a20rst_pulse_gen #(
        .PULSE_CYCLES(PULSE_CYCLES)
    ) i_pulse (
        .clk    (clk),
        .rst_n  (rst_n),
        .start_i(rst_start),
        .pulse_o(cpu_rst)
    );

    a20rst_a20_mux i_mux (
        .speed_up_en(speed_up_en),
        .fw_a20     (state_q.fw_a20),
        .host_a20   (host_a20),
        .alt_a20    (state_q.reg92[1]),
        .a20_o      (a20_gate)
    );

    AST_DIS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!port_en && io_wr) |=> $stable(state_q.reg92));                      // R4
    AST_RD_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
        io_rdata_oe |-> (port_en && io_addr == PORT_ADDR));                   // R3
    AST_A20_OR: assert property (@(posedge clk) disable iff (!rst_n)
        (!speed_up_en && (host_a20 || state_q.reg92[1])) |-> a20_gate);       // R7
    AST_FW_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        (speed_up_en && $past(fw_a20_we)) |-> (a20_gate == $past(fw_a20_wdata))); // R8

endmodule

// File: tb/test_a20rst_port_ctl.sv
`timescale 1ns/1ps
module test_a20rst_port_ctl;

    localparam int PULSE = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_addr = '0;
    logic        io_wr = 1'b0, io_rd = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic        io_rdata_oe;
    logic        port_en = 1'b1, speed_up_en = 1'b0;
    logic        fw_a20_we = 1'b0, fw_a20_wdata = 1'b0, host_a20 = 1'b0;
    logic        a20_gate, cpu_rst;

    always #2.5 clk = ~clk;

    a20rst_port_ctl #(.PULSE_CYCLES(PULSE)) i_a20rst_port_ctl (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .io_rdata_oe(io_rdata_oe),
        .port_en(port_en), .speed_up_en(speed_up_en), .fw_a20_we(fw_a20_we),
        .fw_a20_wdata(fw_a20_wdata), .host_a20(host_a20), .a20_gate(a20_gate),
        .cpu_rst(cpu_rst)
    );

    // Scoreboard item: which output, expected value, requirement tag.
    typedef struct {
        string      req;
        int         sel;   // 0 cpu_rst, 1 a20_gate, 2 io_rdata, 3 io_rdata_oe
        logic [7:0] exp;
    } item_t;

    item_t q[$];
    int    n_checks = 0;
    int    n_errors = 0;
    bit    done = 0;

    task automatic expect_out(input string req, input int sel, input logic [7:0] exp);
        item_t it;
        it.req = req; it.sel = sel; it.exp = exp;
        q.push_back(it);
    endtask

    // Monitor: compare every queued item against the settled outputs.
    always @(negedge clk) begin
        item_t      it;
        logic [7:0] act;
        while (q.size() > 0) begin
            it = q.pop_front();
            case (it.sel)
                0:       act = {7'b0, cpu_rst};
                1:       act = {7'b0, a20_gate};
                2:       act = io_rdata;
                default: act = {7'b0, io_rdata_oe};
            endcase
            n_checks++;
            if (act !== it.exp) begin
                n_errors++;
                $display("FAIL %s sel=%0d actual=%02h expected=%02h", it.req, it.sel, act, it.exp);
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic io_write(input logic [15:0] a, input logic [7:0] d);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        step();
        io_wr = 1'b0;
    endtask

    task automatic io_read_chk(input string req, input logic [15:0] a,
                               input logic oe, input logic [7:0] d);
        io_addr = a; io_rd = 1'b1;
        expect_out(req, 3, {7'b0, oe});
        expect_out(req, 2, d);
        step();
        io_rd = 1'b0;
    endtask

    task automatic fw_write(input logic v);
        fw_a20_wdata = v; fw_a20_we = 1'b1;
        step();
        fw_a20_we = 1'b0;
    endtask

    task automatic finish_run();
        step();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();

        // R1 reset state
        expect_out("R1", 0, 8'h00);
        expect_out("R1", 1, 8'h00);
        step();
        io_read_chk("R1", 16'h0092, 1'b1, 8'h00);

        // R2 write and readback, bit 0 clear so no pulse
        io_write(16'h0092, 8'hA6);
        io_read_chk("R2", 16'h0092, 1'b1, 8'hA6);
        expect_out("R7 alt bit1 opens A20", 1, 8'h01);
        step();

        // R7 OR of host level and bit 1
        io_write(16'h0092, 8'h00);
        expect_out("R7 both low", 1, 8'h00);
        step();
        host_a20 = 1'b1;
        expect_out("R7 host high", 1, 8'h01);
        step();
        host_a20 = 1'b0;
        io_write(16'h0092, 8'h02);
        expect_out("R7 bit1 high", 1, 8'h01);
        step();

        // R3 full-address decode
        io_write(16'h0093, 8'hFF);
        io_write(16'h0192, 8'hFF);
        expect_out("R3 no pulse from alias", 0, 8'h00);
        io_read_chk("R3 reg unchanged", 16'h0092, 1'b1, 8'h02);
        io_read_chk("R3 other addr", 16'h0093, 1'b0, 8'h00);
        io_read_chk("R3 alias addr", 16'h0192, 1'b0, 8'h00);

        // R4 port disabled
        port_en = 1'b0;
        io_write(16'h0092, 8'h01);
        expect_out("R4 no pulse", 0, 8'h00);
        io_read_chk("R4 read undriven", 16'h0092, 1'b0, 8'h00);
        port_en = 1'b1;
        io_read_chk("R4 reg unchanged", 16'h0092, 1'b1, 8'h02);

        // R5 pulse length from a 0-to-1 write
        io_write(16'h0092, 8'h01);
        for (int i = 0; i < PULSE; i++) begin
            expect_out("R5 pulse high", 0, 8'h01);
            step();
        end
        expect_out("R5 pulse ends", 0, 8'h00);
        io_read_chk("R2 bit0 readback", 16'h0092, 1'b1, 8'h01);

        // R6 rewriting 1 over 1 starts nothing
        io_write(16'h0092, 8'h01);
        expect_out("R6 no pulse on 1-to-1", 0, 8'h00);
        step();

        // R6 rising write during pulse does not extend it
        io_write(16'h0092, 8'h00);
        io_write(16'h0092, 8'h01);          // pulse starts, cycle 0
        for (int i = 0; i < 4; i++) begin
            expect_out("R6 pulse high", 0, 8'h01);
            step();
        end
        io_write(16'h0092, 8'h00);
        io_write(16'h0092, 8'h01);          // second rise at cycle 6
        for (int i = 6; i < PULSE; i++) begin
            expect_out("R6 pulse high", 0, 8'h01);
            step();
        end
        expect_out("R6 not extended", 0, 8'h00);
        step();

        // R8 firmware override
        io_write(16'h0092, 8'h00);
        speed_up_en = 1'b1;
        expect_out("R8 fw bit reset low", 1, 8'h00);
        step();
        fw_write(1'b1);
        expect_out("R8 fw high", 1, 8'h01);
        step();
        host_a20 = 1'b1;
        io_write(16'h0092, 8'h02);
        fw_write(1'b0);
        expect_out("R8 host sources masked", 1, 8'h00);
        step();
        speed_up_en = 1'b0;
        expect_out("R7 back to host path", 1, 8'h01);
        step();

        done = 1;
        finish_run();
    end

endmodule